// File: doc/BRIEF.md
# Automatic Controller Serial Poller

This block reads serial game controllers in the background while the display is in its vertical blanking region. It needs no bus cycles from the host processor. A free-running divider makes one poll step every 256 system clocks. A per-frame step counter, cleared by each frame-start pulse, sequences the steps. The steps act only once the current scan line has reached the blanking threshold, which is line 225 normally and line 240 in overscan mode. The divider is never resynchronised to the frame, so the poll starts at a different clock phase each frame.

On the first active step the block pulses the controller latch strobe and raises a busy flag. On each of the first sixteen active steps it pulses the controller clock and shifts one serial bit into every result register. The seventeenth step drops the busy flag, and the block then stays idle until the next frame. The result registers are not cleared before a poll, so a host that reads them during a poll sees old and new bits mixed together.

Top module: `pad_autopoll`

## Requirements
- R1: After a synchronous reset, all four result registers read 0, and the busy flag, latch strobe and clock strobe are all 0.
- R2: A poll step occurs exactly once every 256 clocks, counted from reset. A frame-start pulse does not shift the phase of the steps.
- R3: A step takes effect only when `vline` >= 225 with `overscan`=0, or when `vline` >= 240 with `overscan`=1. Otherwise the outputs do not change.
- R4: On step 0, `pad_latch` goes high for exactly one clock and `poll_busy` rises to 1 on the same clock.
- R5: Steps 0 to 15 each shift the result registers left by one bit, with the new serial bit entering at bit 0. The first bit sampled ends up in bit 15.
- R6: On step 16, `poll_busy` returns to 0. The step counter holds at 16, and no further strobes occur until the next frame-start pulse.
- R7: The step counter advances even when `poll_en`=0. While `poll_en`=0 there is no strobe, no shift and no change to busy. Enabling the poller after the frame's steps have passed produces no poll in that frame.
- R8: Result registers are not cleared before a poll. After k shifts, a register holds its old value shifted left by k, with the k new bits in its low bits.
- R9: A frame-start pulse resets the step counter to 0, so the next qualifying step starts a new poll with a latch strobe.
- R10: The result registers map to the serial inputs as follows: result 0 from `pad_a_d[0]`, result 1 from `pad_b_d[0]`, result 2 from `pad_a_d[1]`, result 3 from `pad_b_d[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-clock pulse at the start of each frame |
| vline | input | 9 | Current vertical line number |
| overscan | input | 1 | Selects the later blanking threshold (240) |
| poll_en | input | 1 | Enables automatic polling |
| pad_a_d | input | 2 | Serial data lanes from controller port A |
| pad_b_d | input | 2 | Serial data lanes from controller port B |
| pad_latch | output | 1 | Controller latch strobe, one clock wide |
| pad_clk | output | 1 | Controller clock strobe, one clock per shifted bit |
| poll_busy | output | 1 | Poll in progress (status bit 0) |
| result0 | output | 16 | Port A lane 0 buttons |
| result1 | output | 16 | Port B lane 0 buttons |
| result2 | output | 16 | Port A lane 1 buttons |
| result3 | output | 16 | Port B lane 1 buttons |

## Verification
The bench checks the line threshold on both sides of each boundary. A design that compares against the wrong line, or ignores overscan, would poll early or never poll. It checks that a frame-start pulse in the middle of a poll restarts the sequence but keeps the 256-clock spacing. A design that clears its divider on each frame would show a shorter gap there. It enables the poller only after the frame's steps have elapsed; a counter that stalls while disabled would then start a late poll. It also reads the result registers after four shifts, which exposes a design that clears the registers first or shifts in the wrong direction.

// File: rtl/padpoll_pkg.sv
package padpoll_pkg;

    localparam int STEP_DIV_W   = 8;
    localparam int LINE_W       = 9;
    localparam int BTN_BITS     = 16;
    localparam int NUM_PORTS    = 2;
    localparam int NUM_LANES    = 2;
    localparam int NUM_SLOTS    = NUM_PORTS * NUM_LANES;
    localparam int STEP_W       = $clog2(BTN_BITS + 1);
    localparam int LINE_STD     = 225;
    localparam int LINE_OVS     = 240;

    typedef struct packed {
        logic latch;
        logic shift;
        logic busy_set;
        logic busy_clr;
    } step_act_t;

    function automatic logic line_open(input logic [LINE_W-1:0] v, input logic ovs);
        if (ovs) return (int'(v) >= LINE_OVS);
        return (int'(v) >= LINE_STD);
    endfunction

    function automatic step_act_t decode_step(input logic [STEP_W-1:0] s, input logic en);
        step_act_t a;
        a.latch    = en && (s == '0);
        a.shift    = en && (int'(s) < BTN_BITS);
        a.busy_set = en && (s == '0);
        a.busy_clr = en && (int'(s) == BTN_BITS);
        return a;
    endfunction

endpackage

// File: rtl/padpoll_divider.sv
module padpoll_divider #(
    parameter int DIV_W = padpoll_pkg::STEP_DIV_W
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign tick = &cnt;

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/padpoll_seq.sv
module padpoll_seq
    import padpoll_pkg::*;
#(
    parameter int BITS = BTN_BITS,
    parameter int SW   = STEP_W,
    parameter int LW   = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          tick,
    input  logic [LW-1:0] vline,
    input  logic          overscan,
    input  logic          poll_en,
    output logic          shift_en,
    output logic          latch_q,
    output logic          shclk_q,
    output logic          busy_q
);
    localparam logic [SW-1:0] STEP_LAST = SW'(BITS);

    logic [SW-1:0] step;
    logic          go;
    step_act_t     act;

    assign go       = tick && line_open(vline, overscan) && !frame_start;
    assign act      = decode_step(step, poll_en);
    assign shift_en = go && act.shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            busy_q  <= 1'b0;
            latch_q <= 1'b0;
            shclk_q <= 1'b0;
        end else begin
            latch_q <= go && act.latch;
            shclk_q <= shift_en;
            if (frame_start)
                step <= '0;
            else if (go && step != STEP_LAST)
                step <= step + 1'b1;
            if (go && act.busy_set)
                busy_q <= 1'b1;
            else if (go && act.busy_clr)
                busy_q <= 1'b0;
        end
    end

    // R4
    latch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        latch_q |-> busy_q);
    // R4
    latch_single_chk: assert property (@(posedge clk) disable iff (rst)
        latch_q |=> !latch_q);
    // R6
    step_sat_chk: assert property (@(posedge clk) disable iff (rst)
        step <= STEP_LAST);
    // R7
    busy_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(poll_en));
    // R3
    shclk_line_chk: assert property (@(posedge clk) disable iff (rst)
        shclk_q |-> $past(line_open(vline, overscan)));

endmodule

// File: rtl/padpoll_shiftbank.sv
module padpoll_shiftbank #(
    parameter int BITS  = padpoll_pkg::BTN_BITS,
    parameter int SLOTS = padpoll_pkg::NUM_SLOTS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [SLOTS-1:0]           din,
    output logic [SLOTS-1:0][BITS-1:0] res
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)           res[g] <= '0;
            else if (shift_en) res[g] <= {res[g][BITS-2:0], din[g]};
        end
    end

    // R5
    shift_bit_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (res[0][0] == $past(din[0])));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(res));

endmodule

// File: rtl/pad_autopoll.sv
module pad_autopoll
    import padpoll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [LINE_W-1:0] vline,
    input  logic              overscan,
    input  logic              poll_en,
    input  logic [1:0]        pad_a_d,
    input  logic [1:0]        pad_b_d,
    output logic              pad_latch,
    output logic              pad_clk,
    output logic              poll_busy,
    output logic [15:0]       result0,
    output logic [15:0]       result1,
    output logic [15:0]       result2,
    output logic [15:0]       result3
);
    logic                               tick;
    logic                               shift_en;
    logic [NUM_SLOTS-1:0]               din;
    logic [NUM_SLOTS-1:0][BTN_BITS-1:0] res;

    // slot order: lane-major, port-minor
    assign din = {pad_b_d[1], pad_a_d[1], pad_b_d[0], pad_a_d[0]};

    padpoll_divider #(.DIV_W(STEP_DIV_W)) u_div (
        .clk(clk), .rst(rst), .tick(tick)
    );

    padpoll_seq #(.BITS(BTN_BITS), .SW(STEP_W), .LW(LINE_W)) u_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start), .tick(tick),
        .vline(vline), .overscan(overscan), .poll_en(poll_en),
        .shift_en(shift_en), .latch_q(pad_latch), .shclk_q(pad_clk),
        .busy_q(poll_busy)
    );

    padpoll_shiftbank #(.BITS(BTN_BITS), .SLOTS(NUM_SLOTS)) u_bank (
        .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .res(res)
    );

    assign result0 = res[0];
    assign result1 = res[1];
    assign result2 = res[2];
    assign result3 = res[3];

    // R10
    map_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (result1[0] == $past(pad_b_d[0])) && (result2[0] == $past(pad_a_d[1])));

endmodule

// File: tb/pad_autopoll_bench.sv
module pad_autopoll_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic [8:0] vline = '0;
    logic overscan = 1'b0;
    logic poll_en = 1'b1;
    logic [1:0] pad_a_d, pad_b_d;
    logic pad_latch, pad_clk, poll_busy;
    logic [15:0] result0, result1, result2, result3;

    always #2.5 clk = ~clk;

    pad_autopoll u_pad_autopoll (
        .clk(clk), .rst(rst), .frame_start(frame_start), .vline(vline),
        .overscan(overscan), .poll_en(poll_en), .pad_a_d(pad_a_d), .pad_b_d(pad_b_d),
        .pad_latch(pad_latch), .pad_clk(pad_clk), .poll_busy(poll_busy),
        .result0(result0), .result1(result1), .result2(result2), .result3(result3)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nlatch = 0, nshift = 0, nfall = 0, latch_bad = 0;
    int idx = 0;
    int last_sh = 0, prev_sh = 0;
    logic busy_prev = 1'b0;
    logic [15:0] w [4];

    function automatic logic bitof(input logic [15:0] word, input int i);
        if (i < 16) return word[15-i];
        return 1'b1;
    endfunction

    always_comb begin
        pad_a_d = {bitof(w[2], idx), bitof(w[0], idx)};
        pad_b_d = {bitof(w[3], idx), bitof(w[1], idx)};
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy_prev && !poll_busy) nfall++;
            busy_prev <= poll_busy;
            if (pad_latch) begin
                nlatch++;
                if (!poll_busy) latch_bad++;
            end
            if (pad_clk) begin
                nshift++;
                idx++;
                prev_sh = last_sh;
                last_sh = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input int base);
        while (nfall == base) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk(result0 == 0 && result1 == 0 && result2 == 0 && result3 == 0, "R1 results", result0, 0);
        chk(!poll_busy && !pad_latch && !pad_clk, "R1 status", poll_busy, 0);
    endtask

    task automatic t_full_poll();
        int l0, s0, f0;
        w[0] = 16'hA53C; w[1] = 16'h0F81; w[2] = 16'h7E12; w[3] = 16'hC3D9;
        l0 = nlatch; s0 = nshift; f0 = nfall;
        idx = 0;
        pulse_frame();
        vline = 9'd230;
        wait_done(f0);
        chk(nlatch - l0 == 1 && latch_bad == 0, "R4 latch with busy", nlatch - l0, 1);
        chk(nshift - s0 == 16, "R5 sixteen shifts", nshift - s0, 16);
        chk(result0 == w[0], "R5 result0", result0, w[0]);
        chk(result1 == w[1], "R10 result1", result1, w[1]);
        chk(result2 == w[2], "R10 result2", result2, w[2]);
        chk(result3 == w[3], "R10 result3", result3, w[3]);
        idle(700);
        chk(nshift - s0 == 16 && !poll_busy, "R6 idle after step 16", nshift - s0, 16);
    endtask

    task automatic t_threshold();
        int s0, f0;
        vline = 9'd0;
        pulse_frame();
        s0 = nshift;
        vline = 9'd224; overscan = 1'b0;
        idle(800);
        chk(nshift == s0 && !poll_busy, "R3 line 224 below", nshift - s0, 0);
        vline = 9'd239; overscan = 1'b1;
        idle(800);
        chk(nshift == s0 && !poll_busy, "R3 line 239 overscan", nshift - s0, 0);
        w[0] = 16'h1357;
        idx = 0; f0 = nfall;
        vline = 9'd240;
        wait_done(f0);
        chk(nshift - s0 == 16 && result0 == 16'h1357, "R3 line 240 overscan", result0, 16'h1357);
        overscan = 1'b0;
    endtask

    task automatic t_disabled();
        int s0, l0;
        logic [15:0] keep;
        keep = result0;
        w[0] = 16'hFFFF;
        vline = 9'd230;
        poll_en = 1'b0;
        idx = 0;
        s0 = nshift; l0 = nlatch;
        pulse_frame();
        idle(20 * 256);
        chk(nshift == s0 && nlatch == l0 && !poll_busy, "R7 no activity while off", nshift - s0, 0);
        poll_en = 1'b1;
        idle(1000);
        chk(nshift == s0 && nlatch == l0 && !poll_busy, "R7 counter advanced while off", nshift - s0, 0);
        chk(result0 == keep, "R7 result kept", result0, keep);
    endtask

    task automatic t_partial();
        int s0, f0;
        logic [15:0] oldv, newv, expv;
        oldv = result0;
        newv = 16'h9C4B;
        w[0] = newv;
        vline = 9'd230;
        idx = 0;
        s0 = nshift; f0 = nfall;
        pulse_frame();
        while (nshift - s0 < 4) @(negedge clk);
        expv = {oldv[11:0], newv[15:12]};
        chk(result0 == expv, "R8 mixed bits after 4 shifts", result0, expv);
        chk(poll_busy, "R8 busy mid poll", poll_busy, 1);
        wait_done(f0);
        chk(result0 == newv, "R8 final value", result0, newv);
    endtask

    task automatic t_phase();
        int s0, l0, f0, gap1, gap2;
        w[1] = 16'h5AA5;
        vline = 9'd230;
        idx = 0;
        s0 = nshift; f0 = nfall;
        pulse_frame();
        while (nshift - s0 < 2) @(negedge clk);
        gap1 = last_sh - prev_sh;
        chk(gap1 == 256, "R2 step spacing", gap1, 256);
        l0 = nlatch;
        s0 = nshift;
        idx = 0;
        pulse_frame();
        while (nshift == s0) @(negedge clk);
        gap2 = last_sh - prev_sh;
        chk(gap2 == 256, "R2 phase kept over frame start", gap2, 256);
        chk(nlatch - l0 == 1, "R9 restart latch", nlatch - l0, 1);
        wait_done(f0);
        chk(result1 == 16'h5AA5, "R9 restarted poll result", result1, 16'h5AA5);
    endtask

    initial begin
        t_reset();
        t_full_poll();
        t_threshold();
        t_disabled();
        t_partial();
        t_phase();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule